// File: doc/BRIEF.md
# Unlock Sequence Decoder

This block sits beside the write port of a byte-wide, sector-programmed flash memory. It watches every byte write (address and data) for a few fixed multi-write unlock sequences. A two-write prefix is followed by one final byte, or by an extended form that repeats the prefix. The final byte chooses the action: arm write protection, disarm it, enter or leave the identification mode, or arm a one-shot boot-block lock. Only the low 15 address bits are compared when a command is matched.

For each write the block reports whether the write was taken as part of a command, whether it may be programmed, or whether it is refused. A write can be refused because protection is on and no unlock window is open, or because the write falls in a locked boot block. The protection flag and the two lock flags are non-volatile: reset does not clear them. A change to protection takes effect when the external sector buffer signals the end of the load period. While identification mode is on, a separate read address returns fixed identification codes and boot-block lock status. The sector buffer and the array are outside this block.

Top module: `unlock_seq_dec`

## Requirements
- R1: Commands match on address bits 14..0 only. The prefix is 0xAA written to 0x5555, then 0x55 written to 0x2AAA. Address bits above 14 are ignored for every command write.
- R2: Prefix then 0xA0 to 0x5555 opens a program window (data_gate_o=1) and arms protection. prot_o becomes 1 in the cycle after the next load_done_i pulse.
- R3: Prefix, 0x80 to 0x5555, prefix, 0x20 to 0x5555 opens a program window and arms release. prot_o becomes 0 in the cycle after the next load_done_i pulse.
- R4: Prefix then 0x90 to 0x5555 sets id_mode_o. Prefix then 0xF0 to 0x5555 clears it.
- R5: In identification mode, a read address outside the two status locations returns 0x1F when bit 0 is 0 and 0xDA when bit 0 is 1. Outside identification mode id_data_o is 0x00.
- R6: In identification mode, read address 2 returns the lower-block status and the address with all bits above BOOT_W set and low bits equal to 2 returns the upper-block status. The status byte is 0xFE when unlocked and 0xFF when locked.
- R7: Prefix, 0x80, prefix, 0x40 to 0x5555 arms a lock. The next write sets lock_lo_o if it is 0x00 to full address 0, or sets lock_hi_o if it is 0xFF to the all-ones full address. A lock flag never clears.
- R8: While prot_o=1 and no window is open, a data write gives blocked_o=1 and prog_ok_o=0. With protection off, or inside an open window, a data write gives prog_ok_o=1. load_done_i closes the window.
- R9: A write that does not continue the sequence in progress returns the matcher to idle. That write is handled as an ordinary data write.
- R10: rst_ni clears the identification mode, the window and any armed change. It leaves prot_o, lock_lo_o and lock_hi_o unchanged.
- R11: A data write whose address bits above BOOT_W are all 0 (lower block) or all 1 (upper block) is refused (blocked_o=1) while that block's lock flag is set.
- R12: A write that continues or completes a command sequence gives prog_ok_o=0 and blocked_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the volatile state |
| wr_en_i | input | 1 | One byte write this cycle |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| load_done_i | input | 1 | End of the sector load period (pulse) |
| rd_addr_i | input | ADDR_W | Identification read address |
| prot_o | output | 1 | Write protection active |
| id_mode_o | output | 1 | Identification mode active |
| lock_lo_o | output | 1 | Lower boot block locked |
| lock_hi_o | output | 1 | Upper boot block locked |
| data_gate_o | output | 1 | Data writes may be programmed now |
| prog_ok_o | output | 1 | Current write is a data write to be programmed |
| blocked_o | output | 1 | Current write is a data write that is refused |
| id_data_o | output | 8 | Identification or status byte for rd_addr_i |

## Verification
The bench builds the block with ADDR_W=16 and BOOT_W=4. With these values each boot block is 16 bytes, so a full sweep of both locked blocks and their neighbours is cheap. The whole 64K read space in identification mode can also be swept against codes computed in the bench. Bit 15 is a spare address bit above the command field, so the bench can check that command matching ignores it. Every value of the final command byte is also swept to cover the break path.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int CMD_W = 15;

  localparam logic [CMD_W-1:0] ADR_A = 15'h5555;
  localparam logic [CMD_W-1:0] ADR_B = 15'h2AAA;

  localparam logic [7:0] C_KEY1   = 8'hAA;
  localparam logic [7:0] C_KEY2   = 8'h55;
  localparam logic [7:0] C_ARM    = 8'hA0;
  localparam logic [7:0] C_EXT    = 8'h80;
  localparam logic [7:0] C_ID_IN  = 8'h90;
  localparam logic [7:0] C_ID_OUT = 8'hF0;
  localparam logic [7:0] C_REL    = 8'h20;
  localparam logic [7:0] C_LOCK   = 8'h40;

  localparam logic [7:0] ID_MFR    = 8'h1F;
  localparam logic [7:0] ID_DEV    = 8'hDA;
  localparam logic [7:0] ST_FREE   = 8'hFE;
  localparam logic [7:0] ST_LOCKED = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_P1, S_P2, S_X1, S_X2, S_X3, S_LK
  } seq_e;

  typedef struct packed {
    logic       prot_on;
    logic       prot_off;
    logic       id_on;
    logic       id_off;
    logic [1:0] lock;
  } cmd_ev_t;
endpackage

// File: rtl/seq_matcher.sv
module seq_matcher
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output cmd_ev_t           ev_o,
  output logic              consumed_o
);
  seq_e state_q, state_d;
  logic at_a, at_b, at_zero, at_top;

  assign at_a    = wr_addr_i[CMD_W-1:0] == ADR_A;
  assign at_b    = wr_addr_i[CMD_W-1:0] == ADR_B;
  assign at_zero = wr_addr_i == '0;
  assign at_top  = wr_addr_i == '1;

  always_comb begin
    state_d    = state_q;
    ev_o       = '0;
    consumed_o = 1'b0;
    if (wr_en_i) begin
      state_d = S_IDLE;
      unique case (state_q)
        S_IDLE, S_X1: begin
          if (at_a && wr_data_i == C_KEY1) begin
            state_d    = (state_q == S_IDLE) ? S_P1 : S_X2;
            consumed_o = 1'b1;
          end
        end
        S_P1, S_X2: begin
          if (at_b && wr_data_i == C_KEY2) begin
            state_d    = (state_q == S_P1) ? S_P2 : S_X3;
            consumed_o = 1'b1;
          end
        end
        S_P2: begin
          if (at_a) begin
            consumed_o = 1'b1;
            unique case (wr_data_i)
              C_ARM:    ev_o.prot_on = 1'b1;
              C_ID_IN:  ev_o.id_on   = 1'b1;
              C_ID_OUT: ev_o.id_off  = 1'b1;
              C_EXT:    state_d      = S_X1;
              default:  consumed_o   = 1'b0;
            endcase
          end
        end
        S_X3: begin
          if (at_a && wr_data_i == C_REL) begin
            ev_o.prot_off = 1'b1;
            consumed_o    = 1'b1;
          end else if (at_a && wr_data_i == C_LOCK) begin
            state_d    = S_LK;
            consumed_o = 1'b1;
          end
        end
        S_LK: begin
          if (at_zero && wr_data_i == 8'h00) begin
            ev_o.lock[0] = 1'b1;
            consumed_o   = 1'b1;
          end else if (at_top && wr_data_i == 8'hFF) begin
            ev_o.lock[1] = 1'b1;
            consumed_o   = 1'b1;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/mode_regs.sv
module mode_regs
  import unlock_pkg::*;
#(
  parameter bit PROT_INIT = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cmd_ev_t    ev_i,
  input  logic       load_done_i,
  output logic       prot_o,
  output logic [1:0] lock_o,
  output logic       id_mode_o,
  output logic       win_o
);
  // non-volatile bits: power-up value only, untouched by rst_ni
  logic       prot_q = PROT_INIT;
  logic [1:0] lock_q = 2'b00;
  logic       pend_on_q, pend_off_q, win_q, id_q;

  always_ff @(posedge clk_i) begin
    if (load_done_i && pend_on_q)       prot_q <= 1'b1;
    else if (load_done_i && pend_off_q) prot_q <= 1'b0;
    lock_q <= lock_q | ev_i.lock;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_on_q  <= 1'b0;
      pend_off_q <= 1'b0;
      win_q      <= 1'b0;
      id_q       <= 1'b0;
    end else begin
      if (ev_i.prot_on) begin
        pend_on_q  <= 1'b1;
        pend_off_q <= 1'b0;
      end else if (ev_i.prot_off) begin
        pend_on_q  <= 1'b0;
        pend_off_q <= 1'b1;
      end else if (load_done_i) begin
        pend_on_q  <= 1'b0;
        pend_off_q <= 1'b0;
      end

      if (ev_i.prot_on || ev_i.prot_off) win_q <= 1'b1;
      else if (load_done_i)              win_q <= 1'b0;

      if (ev_i.id_on)       id_q <= 1'b1;
      else if (ev_i.id_off) id_q <= 1'b0;
    end
  end

  assign prot_o    = prot_q;
  assign lock_o    = lock_q;
  assign id_mode_o = id_q;
  assign win_o     = win_q;
endmodule

// File: rtl/boot_guard.sv
module boot_guard #(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        lock_i,
  output logic [1:0]        in_blk_o,
  output logic              hit_locked_o
);
  localparam int TOP_W = ADDR_W - BOOT_W;

  for (genvar b = 0; b < 2; b++) begin : g_blk
    localparam logic [TOP_W-1:0] TAG = (b == 0) ? '0 : '1;
    assign in_blk_o[b] = addr_i[ADDR_W-1:BOOT_W] == TAG;
  end

  assign hit_locked_o = |(in_blk_o & lock_i);
endmodule

// File: rtl/id_rom.sv
module id_rom
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              id_mode_i,
  input  logic [1:0]        lock_i,
  output logic [7:0]        data_o
);
  logic [1:0] in_blk;
  logic       unused_hit;
  logic       st_loc;

  boot_guard #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_blk (
    .addr_i      (rd_addr_i),
    .lock_i      (2'b00),
    .in_blk_o    (in_blk),
    .hit_locked_o(unused_hit)
  );

  assign st_loc = rd_addr_i[BOOT_W-1:0] == BOOT_W'(2);

  always_comb begin
    if (!id_mode_i)                 data_o = 8'h00;
    else if (st_loc && in_blk[0])   data_o = lock_i[0] ? ST_LOCKED : ST_FREE;
    else if (st_loc && in_blk[1])   data_o = lock_i[1] ? ST_LOCKED : ST_FREE;
    else if (rd_addr_i[0])          data_o = ID_DEV;
    else                            data_o = ID_MFR;
  end
endmodule

// File: rtl/unlock_seq_dec.sv
module unlock_seq_dec
  import unlock_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BOOT_W    = 13,
  parameter bit PROT_INIT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              load_done_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              prot_o,
  output logic              id_mode_o,
  output logic              lock_lo_o,
  output logic              lock_hi_o,
  output logic              data_gate_o,
  output logic              prog_ok_o,
  output logic              blocked_o,
  output logic [7:0]        id_data_o
);
  cmd_ev_t    ev;
  logic       consumed, win, hit_locked, data_wr;
  logic [1:0] lock, wr_blk;

  seq_matcher #(.ADDR_W(ADDR_W)) u_match (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ev_o      (ev),
    .consumed_o(consumed)
  );

  mode_regs #(.PROT_INIT(PROT_INIT)) u_mode (
    .clk_i, .rst_ni,
    .ev_i       (ev),
    .load_done_i,
    .prot_o,
    .lock_o     (lock),
    .id_mode_o,
    .win_o      (win)
  );

  boot_guard #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_guard (
    .addr_i      (wr_addr_i),
    .lock_i      (lock),
    .in_blk_o    (wr_blk),
    .hit_locked_o(hit_locked)
  );

  id_rom #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_id (
    .rd_addr_i,
    .id_mode_i(id_mode_o),
    .lock_i   (lock),
    .data_o   (id_data_o)
  );

  assign lock_lo_o   = lock[0];
  assign lock_hi_o   = lock[1];
  assign data_gate_o = !prot_o || win;
  assign data_wr     = wr_en_i && !consumed;
  assign prog_ok_o   = data_wr && data_gate_o && !hit_locked;
  assign blocked_o   = data_wr && !prog_ok_o;
endmodule

// File: rtl/unlock_seq_dec_chk.sv
module unlock_seq_dec_chk #(
  parameter int ADDR_W = 18,
  parameter int BOOT_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              load_done_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              prot_o,
  input logic              id_mode_o,
  input logic              lock_lo_o,
  input logic              lock_hi_o,
  input logic              prog_ok_o,
  input logic              blocked_o,
  input logic [7:0]        id_data_o
);
  p_prot_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_done_i) |-> $stable(prot_o));

  p_lock_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lock_lo_o) && $past(lock_hi_o) |-> lock_lo_o && lock_hi_o);

  p_lock_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_lo_o) |-> $past(wr_en_i && wr_addr_i == '0 && wr_data_i == 8'h00));

  p_id_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_mode_o) |-> $past(wr_en_i && wr_data_i == 8'h90));

  p_locked_refuse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_ok_o |-> !(lock_lo_o && wr_addr_i[ADDR_W-1:BOOT_W] == '0) &&
                  !(lock_hi_o && wr_addr_i[ADDR_W-1:BOOT_W] == '1));

  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_ok_o || blocked_o) |-> wr_en_i && !(prog_ok_o && blocked_o));

  p_id_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_mode_o && rd_addr_i[BOOT_W-1:0] != BOOT_W'(2)
      |-> id_data_o == (rd_addr_i[0] ? 8'hDA : 8'h1F));
endmodule

bind unlock_seq_dec unlock_seq_dec_chk #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .load_done_i, .rd_addr_i,
  .prot_o, .id_mode_o, .lock_lo_o, .lock_hi_o, .prog_ok_o, .blocked_o, .id_data_o
);

// File: tb/sim_unlock_seq_dec.sv
`timescale 1ns/1ps
module sim_unlock_seq_dec;
  localparam int AW = 16;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          load_done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          prot, id_mode, lock_lo, lock_hi, gate, ok, blk;
  logic [7:0]    id_data;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  logic last_ok, last_blk;

  always #2.5 clk = ~clk;

  unlock_seq_dec #(.ADDR_W(AW), .BOOT_W(BW), .PROT_INIT(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .load_done_i(load_done), .rd_addr_i(rd_addr),
    .prot_o(prot), .id_mode_o(id_mode), .lock_lo_o(lock_lo), .lock_hi_o(lock_hi),
    .data_gate_o(gate), .prog_ok_o(ok), .blocked_o(blk), .id_data_o(id_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    last_ok = ok; last_blk = blk;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic prefix(logic hi);
    wr({hi, 15'h5555}, 8'hAA);
    chk("R12 key1 consumed", {last_ok, last_blk}, 2'b00);
    wr({hi, 15'h2AAA}, 8'h55);
    chk("R12 key2 consumed", {last_ok, last_blk}, 2'b00);
  endtask

  function automatic logic [7:0] exp_id(logic [AW-1:0] a, logic llo, logic lhi);
    if (a[BW-1:0] == 4'd2 && a[AW-1:BW] == '0) return llo ? 8'hFF : 8'hFE;
    if (a[BW-1:0] == 4'd2 && a[AW-1:BW] == '1) return lhi ? 8'hFF : 8'hFE;
    return a[0] ? 8'hDA : 8'h1F;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk("R10 reset prot", prot, 0);
    chk("R10 reset id", id_mode, 0);
    chk("R10 reset locks", {lock_lo, lock_hi}, 0);
    chk("R8 reset gate", gate, 1);
    chk("R5 id_data outside id", id_data, 8'h00);

    // R9: sweep every final byte that is not a command
    for (int d = 0; d < 256; d++) begin
      if (d == 8'hA0 || d == 8'h90 || d == 8'hF0 || d == 8'h80) continue;
      prefix(1'b0);
      wr(16'h5555, 8'(d));
      chk("R9 break write programs", {last_ok, last_blk}, 2'b10);
      chk("R9 no mode change", {prot, id_mode}, 2'b00);
    end
    wr(16'h5555, 8'hAA);
    wr(16'h1234, 8'h77);
    chk("R9 break at step two", {last_ok, last_blk}, 2'b10);
    wr(16'h2AAA, 8'h55);
    chk("R9 idle after break", {last_ok, last_blk}, 2'b10);

    // R1/R4: enter id with bit 15 set on command addresses
    prefix(1'b1);
    wr(16'hD555, 8'h90);
    chk("R12 id enter consumed", {last_ok, last_blk}, 2'b00);
    chk("R1 R4 id entered", id_mode, 1);

    // R5/R6: full read sweep
    for (int a = 0; a < 65536; a++) begin
      rd_addr = 16'(a);
      #1;
      chk("R5 R6 id read", id_data, exp_id(16'(a), 1'b0, 1'b0));
    end

    prefix(1'b0);
    wr(16'h5555, 8'hF0);
    chk("R4 id exited", id_mode, 0);
    rd_addr = 16'h0001; #1;
    chk("R5 id_data after exit", id_data, 8'h00);

    // R2: arm protection
    prefix(1'b0);
    wr(16'h5555, 8'hA0);
    chk("R2 prot not yet", prot, 0);
    chk("R2 window open", gate, 1);
    wr(16'h0100, 8'h3C);
    chk("R2 sector write ok", {last_ok, last_blk}, 2'b10);
    pulse_done();
    chk("R2 prot on after done", prot, 1);
    chk("R8 window closed", gate, 0);

    // R8: protected write refused, unlocked window allowed
    wr(16'h1000, 8'h11);
    chk("R8 protected refused", {last_ok, last_blk}, 2'b01);
    chk("R8 prot unchanged", prot, 1);
    prefix(1'b0);
    wr(16'h5555, 8'hA0);
    chk("R8 window reopened", gate, 1);
    wr(16'h1000, 8'h11);
    chk("R8 window write ok", {last_ok, last_blk}, 2'b10);
    pulse_done();
    chk("R8 window closed again", {gate, prot}, 2'b01);

    // R10: reset keeps protection, clears id and window
    prefix(1'b0);
    wr(16'h5555, 8'h90);
    prefix(1'b0);
    wr(16'h5555, 8'hA0);
    chk("R10 pre reset", {id_mode, gate}, 2'b11);
    do_reset();
    #1;
    chk("R10 prot kept", prot, 1);
    chk("R10 id cleared", id_mode, 0);
    chk("R10 window cleared", gate, 0);
    pulse_done();
    chk("R10 armed change dropped", prot, 1);

    // R3: release protection, mixed upper address bit
    prefix(1'b1);
    wr(16'h5555, 8'h80);
    prefix(1'b0);
    wr(16'hD555, 8'h20);
    chk("R12 release consumed", {last_ok, last_blk}, 2'b00);
    chk("R3 window open, prot kept", {gate, prot}, 2'b11);
    pulse_done();
    chk("R3 prot off after done", prot, 0);

    // R7: lock arm broken by a wrong target
    prefix(1'b0); wr(16'h5555, 8'h80);
    prefix(1'b0); wr(16'h5555, 8'h40);
    wr(16'h0001, 8'h00);
    chk("R7 R9 wrong target is data", {last_ok, last_blk}, 2'b10);
    chk("R7 no lock", {lock_lo, lock_hi}, 2'b00);

    prefix(1'b0); wr(16'h5555, 8'h80);
    prefix(1'b0); wr(16'h5555, 8'h40);
    wr(16'h0000, 8'h00);
    chk("R7 lower locked", {lock_lo, lock_hi}, 2'b10);
    for (int a = 0; a < 32; a++) begin
      wr(16'(a), 8'h5A);
      chk("R11 lower block sweep", {last_ok, last_blk}, (a < 16) ? 2'b01 : 2'b10);
    end

    prefix(1'b0); wr(16'h5555, 8'h80);
    prefix(1'b0); wr(16'h5555, 8'h40);
    wr(16'hFFFF, 8'hFF);
    chk("R7 upper locked", {lock_lo, lock_hi}, 2'b11);
    for (int a = 16'hFFE0; a < 65536; a++) begin
      wr(16'(a), 8'hA5);
      chk("R11 upper block sweep", {last_ok, last_blk}, (a >= 16'hFFF0) ? 2'b01 : 2'b10);
    end

    do_reset();
    #1;
    chk("R10 locks kept", {lock_lo, lock_hi}, 2'b11);
    prefix(1'b0);
    wr(16'h5555, 8'h90);
    rd_addr = 16'h0002; #1;
    chk("R6 lower status locked", id_data, 8'hFF);
    rd_addr = 16'hFFF2; #1;
    chk("R6 upper status locked", id_data, 8'hFF);
    rd_addr = 16'h0012; #1;
    chk("R5 non-status address", id_data, 8'h1F);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule